// File: doc/BRIEF.md
# Cyclic Uplink Damping Modulator

This block produces the load-switch control that a passive transponder uses to send its stored memory back to a reader. It runs on the recovered field clock. It reads 32-bit words from a small synchronous memory and turns them into a continuous serial stream. It then encodes each bit either as a Manchester pattern or as phase shifts of a subcarrier at half the field clock. The resulting level drives the damping switch.

Word 0 of the memory holds the configuration:

- Bits [4:0]: the last word of the cycle.
- Bit 5: selects PSK when 1, Manchester when 0.
- Bit 6: selects the slow bit rate (32 field clocks per bit) when 1, the fast rate (16 field clocks per bit) when 0.
- Bit 7: silences the output when 1.

Word 0 is re-read ahead of every word fetch. The new value takes effect at the next word boundary.

Each time the stream is entered it begins with a single zero start bit. It then sends word 1 up to the last word and wraps back to word 1. A direct-select input makes one chosen word repeat instead. Dropping the enable input (for example while the reader is talking to the tag) stops the block at once.

Top module: `uplink_modulator`

## Requirements
- R1: After enable rises (or reset ends with enable high), the first bit sent is a start bit of value 0. No start bit is sent again until enable drops and rises.
- R2: After the start bit, words 1, 2, … up to the last-word field (config bits [4:0]) are sent in order, most significant bit first. The stream then returns to word 1 with no gap and no extra bit.
- R3: When the last-word field is 0, word 0 itself (all 32 bits) is sent repeatedly.
- R4: While direct_en is high, only the word at direct_addr is sent, repeatedly, whatever the last-word field holds.
- R5: One bit lasts 16 field clocks when config bit 6 is 0, and 32 field clocks when it is 1.
- R6: With config bit 5 at 0 (Manchester), damp_out holds the inverse of the bit for the first half of the bit and the bit itself for the second half. A 1 is therefore a rising mid-bit transition and a 0 a falling one.
- R7: With config bit 5 at 1 (PSK), damp_out toggles on every field clock. Its phase inverts at each change of data value: at even clock offsets within a bit the output equals the bit, so the first inversion after the zero start bit marks a 0-to-1 change.
- R8: The configuration is re-read before every word fetch: memory reads come in pairs, and the first read of each pair is at address 0.
- R9: With config bit 7 at 1, damp_out stays 0 while memory reads and sequencing continue.
- R10: One cycle after enable is seen low, damp_out and mem_rd_en are 0. When enable returns, the stream restarts with the start bit and word 1.
- R11: During and after synchronous reset, damp_out and mem_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered field clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Uplink transmission enable |
| direct_en | input | 1 | Repeat a single selected word |
| direct_addr | input | 5 | Word selected when direct_en is high |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 5 | Memory read address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| damp_out | output | 1 | Registered damping switch control |

## Verification
The main stream is decoded from damp_out under four configurations:

- **Manchester, fast rate, two-word cycle:** confirms the wrap back to word 1.
- **PSK, slow rate, three-word cycle:** separates the two bit periods, because sampling at the wrong period scrambles every word.
- **Direct select with a larger last-word value:** shows that the last-word field is overridden.
- **Last-word value of zero:** shows that the configuration word itself is sent.

Each word is checked bit for bit, and every bit's two samples must differ, which separates correct coding from a stuck or unmodulated output. Separate sequences check the restart after enable drops, and the silenced output while the read traffic that proves sequencing continues.

// File: rtl/um_pkg.sv
package um_pkg;

  localparam int UM_ADDR_W = 5;
  localparam int UM_CFG_W  = UM_ADDR_W + 3;

  typedef struct packed {
    logic                 defeat;
    logic                 slow;
    logic                 psk;
    logic [UM_ADDR_W-1:0] last;
  } um_cfg_t;

  typedef enum logic [1:0] {SQ_OFF, SQ_PRIME, SQ_TX} sq_state_t;

  typedef enum logic [2:0] {
    F_IDLE, F_CFG_ISS, F_CFG_LAT, F_DAT_ISS, F_DAT_LAT
  } fetch_state_t;

  function automatic um_cfg_t cfg_from_bits(input logic [UM_CFG_W-1:0] b);
    return um_cfg_t'(b);
  endfunction

  // Word that follows 'cur' in the uplink cycle
  function automatic logic [UM_ADDR_W-1:0] next_block(
    input um_cfg_t              c,
    input logic [UM_ADDR_W-1:0] cur,
    input logic                 first,
    input logic                 dir,
    input logic [UM_ADDR_W-1:0] daddr
  );
    logic [UM_ADDR_W-1:0] n;
    if (dir)                  n = daddr;
    else if (c.last == '0)    n = '0;
    else if (first)           n = UM_ADDR_W'(1);
    else if (cur >= c.last)   n = UM_ADDR_W'(1);
    else                      n = cur + UM_ADDR_W'(1);
    return n;
  endfunction

endpackage

// File: rtl/um_fetch.sv
module um_fetch
  import um_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int ADDR_W = UM_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              kick,
  input  logic              first_in,
  input  logic              direct_en,
  input  logic [ADDR_W-1:0] direct_addr,
  input  logic [ADDR_W-1:0] cur_blk,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output um_cfg_t           cfg_pend,
  output logic [DATA_W-1:0] data_buf,
  output logic [ADDR_W-1:0] blk_buf,
  output logic              done
);

  fetch_state_t st;
  logic         first_q;
  um_cfg_t      cfg_rd;
  logic [ADDR_W-1:0] nxt;

  assign cfg_rd = cfg_from_bits(mem_rd_data[UM_CFG_W-1:0]);
  assign nxt    = next_block(cfg_rd, cur_blk, first_q, direct_en, direct_addr);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || clr) begin
      st        <= F_IDLE;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      first_q   <= 1'b0;
      if (rst) begin
        cfg_pend <= '0;
        data_buf <= '0;
        blk_buf  <= '0;
      end
    end else begin
      case (st)
        F_IDLE: if (kick) begin
          mem_rd_en <= 1'b1;
          mem_addr  <= '0;
          first_q   <= first_in;
          st        <= F_CFG_ISS;
        end
        F_CFG_ISS: begin
          mem_rd_en <= 1'b0;
          st        <= F_CFG_LAT;
        end
        F_CFG_LAT: begin
          cfg_pend  <= cfg_rd;
          mem_rd_en <= 1'b1;
          mem_addr  <= nxt;
          blk_buf   <= nxt;
          st        <= F_DAT_ISS;
        end
        F_DAT_ISS: begin
          mem_rd_en <= 1'b0;
          st        <= F_DAT_LAT;
        end
        F_DAT_LAT: begin
          data_buf <= mem_rd_data;
          done     <= 1'b1;
          st       <= F_IDLE;
        end
        default: st <= F_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/um_bit_timer.sv
module um_bit_timer #(
  parameter  int FAST_BIT = 16,
  parameter  int SLOW_BIT = 32,
  localparam int CNT_W    = $clog2(SLOW_BIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic sub_phase,
  output logic first_half,
  output logic bit_end
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   period;

  assign period     = slow ? (CNT_W+1)'(SLOW_BIT) : (CNT_W+1)'(FAST_BIT);
  assign bit_end    = run && ({1'b0, cnt} == period - 1'b1);
  assign first_half = {1'b0, cnt} < (period >> 1);
  assign sub_phase  = cnt[0];

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (bit_end) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/um_encoder.sv
module um_encoder (
  input  logic bit_val,
  input  logic psk,
  input  logic first_half,
  input  logic sub_phase,
  output logic level
);

  always_comb begin
    if (psk) level = sub_phase ^ bit_val;
    else     level = first_half ? ~bit_val : bit_val;
  end

endmodule

// File: rtl/uplink_modulator.sv
module uplink_modulator
  import um_pkg::*;
#(
  parameter  int DATA_W   = 32,
  parameter  int FAST_BIT = 16,
  parameter  int SLOW_BIT = 32,
  localparam int ADDR_W   = UM_ADDR_W,
  localparam int IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              direct_en,
  input  logic [ADDR_W-1:0] direct_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              damp_out
);

  sq_state_t         state;
  um_cfg_t           cfg_q;
  um_cfg_t           cfg_pend;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] data_buf;
  logic [ADDR_W-1:0] blk_buf;
  logic [ADDR_W-1:0] cur_blk;
  logic [IDX_W-1:0]  bidx;
  logic              start_bit;
  logic              fetch_done;
  logic              sub_phase, first_half, bit_end;
  logic              cur_bit, level;
  logic              load_evt, kick;

  assign cur_bit  = start_bit ? 1'b0 : shreg[DATA_W-1];
  assign load_evt = (state == SQ_TX) && bit_end &&
                    (start_bit || (bidx == IDX_W'(DATA_W-1)));
  assign kick     = enable && ((state == SQ_OFF) || load_evt);

  um_fetch #(.DATA_W(DATA_W)) fetch_i (
    .clk         (clk),
    .rst         (rst),
    .clr         (!enable),
    .kick        (kick),
    .first_in    (state == SQ_OFF),
    .direct_en   (direct_en),
    .direct_addr (direct_addr),
    .cur_blk     (cur_blk),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .cfg_pend    (cfg_pend),
    .data_buf    (data_buf),
    .blk_buf     (blk_buf),
    .done        (fetch_done)
  );

  um_bit_timer #(.FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .run        (state == SQ_TX),
    .slow       (cfg_q.slow),
    .sub_phase  (sub_phase),
    .first_half (first_half),
    .bit_end    (bit_end)
  );

  um_encoder enc_i (
    .bit_val    (cur_bit),
    .psk        (cfg_q.psk),
    .first_half (first_half),
    .sub_phase  (sub_phase),
    .level      (level)
  );

  // Sequencer: start bit, then words, wrapping without a gap
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state     <= SQ_OFF;
      start_bit <= 1'b0;
      bidx      <= '0;
      shreg     <= '0;
      cur_blk   <= '0;
      if (rst) cfg_q <= '0;
    end else begin
      case (state)
        SQ_OFF:   state <= SQ_PRIME;
        SQ_PRIME: if (fetch_done) begin
          state     <= SQ_TX;
          cfg_q     <= cfg_pend;
          start_bit <= 1'b1;
          bidx      <= '0;
        end
        SQ_TX: if (load_evt) begin
          shreg     <= data_buf;
          cur_blk   <= blk_buf;
          cfg_q     <= cfg_pend;
          start_bit <= 1'b0;
          bidx      <= '0;
        end else if (bit_end) begin
          shreg <= shreg << 1;
          bidx  <= bidx + 1'b1;
        end
        default: state <= SQ_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) damp_out <= 1'b0;
    else                damp_out <= (state == SQ_TX) && !cfg_q.defeat && level;
  end

endmodule

// File: rtl/um_checker.sv
module um_checker #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              damp_out,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cfg_defeat
);

  logic pair_ph;

  always_ff @(posedge clk) begin
    if (rst || !enable) pair_ph <= 1'b0;
    else if (mem_rd_en) pair_ph <= ~pair_ph;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!damp_out && !mem_rd_en)); // R11
  AST_OFF_NO_DAMP: assert property (@(posedge clk) disable iff (rst) !enable |=> !damp_out); // R10
  AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (rst) !enable |=> !mem_rd_en); // R10
  AST_CFG_READ_FIRST: assert property (@(posedge clk) disable iff (rst)
    (enable && mem_rd_en && !pair_ph) |-> (mem_addr == '0)); // R8
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst) mem_rd_en |=> !mem_rd_en); // R8
  AST_DEFEAT_SILENT: assert property (@(posedge clk) disable iff (rst) cfg_defeat |=> !damp_out); // R9

endmodule

bind uplink_modulator um_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .damp_out   (damp_out),
  .mem_rd_en  (mem_rd_en),
  .mem_addr   (mem_addr),
  .cfg_defeat (cfg_q.defeat)
);

// File: tb/uplink_modulator_tb_top.sv
`timescale 1ns/1ps
module uplink_modulator_tb_top;
  import um_pkg::*;

  localparam int DATA_W = 32;
  localparam int ADDR_W = UM_ADDR_W;
  localparam int NWORDS = 2**ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              enable = 1'b0;
  logic              direct_en = 1'b0;
  logic [ADDR_W-1:0] direct_addr = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic              damp_out;
  logic [DATA_W-1:0] mem [NWORDS];

  int errors = 0;
  int checks = 0;
  int rd_cnt = 0;
  int ord_viol = 0;
  bit ph = 1'b0;

  always #2 clk = ~clk;

  uplink_modulator dut_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .direct_en   (direct_en),
    .direct_addr (direct_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .mem_rd_data (mem_rd_data),
    .damp_out    (damp_out)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr];

  // Read-order monitor for R8
  always @(posedge clk) begin
    if (rst || !enable) ph = 1'b0;
    else if (mem_rd_en) begin
      if (!ph && mem_addr != '0) ord_viol++;
      ph = ~ph;
      rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(input bit defeat, input bit slow,
                                       input bit psk, input int last);
    return {24'h5AC3E1, defeat, slow, psk, last[4:0]};
  endfunction

  function automatic int exp_blk(input int j, input int last, input bit dir, input int daddr);
    if (dir) return daddr;
    if (last == 0) return 0;
    return (j % last) + 1;
  endfunction

  task automatic stop_tx();
    @(negedge clk);
    enable = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Decode the uplink stream from damp_out and compare words
  task automatic decode(input string req, input bit psk, input bit slow, input int nblk,
                        input int last, input bit dir, input int daddr);
    int p = slow ? 32 : 16;
    int h = p / 2;
    int f0 = psk ? 1 : 0;
    int t = 0;
    int waitc = 0;
    bit a, b, val, enc_ok;
    logic [31:0] word = '0;
    string enc_req = psk ? "R7" : "R6";
    while (damp_out !== 1'b1 && waitc < 400) begin
      @(negedge clk);
      waitc++;
    end
    chk(damp_out === 1'b1, "R1", "stream start seen", {31'b0, damp_out}, 32'd1);
    if (damp_out !== 1'b1) return;
    enc_ok = 1'b1;
    for (int k = 0; k < 1 + 32*nblk; k++) begin
      int base = k*p - f0;
      int o1 = psk ? base + 2 : base + h/2;
      int o2 = psk ? base + 3 : base + h + h/2;
      while (t < o1) begin @(negedge clk); t++; end
      a = damp_out;
      while (t < o2) begin @(negedge clk); t++; end
      b = damp_out;
      val = psk ? a : b;
      if (k == 0) begin
        chk(val == 1'b0, "R1", "start bit value", {31'b0, val}, 32'd0);
        chk(a != b, enc_req, "start bit coding", {31'b0, a}, {31'b0, ~b});
      end else begin
        word = {word[30:0], val};
        if (a == b) enc_ok = 1'b0;
        if ((k-1) % 32 == 31) begin
          int j = (k-1) / 32;
          logic [31:0] exp = mem[exp_blk(j, last, dir, daddr)];
          chk(word == exp, req, $sformatf("word %0d of stream", j), word, exp);
          chk(enc_ok, enc_req, "per-bit coding", {31'b0, enc_ok}, 32'd1);
          enc_ok = 1'b1;
        end
      end
    end
  endtask

  task automatic start_tx(input logic [31:0] cfg, input bit dir, input int daddr);
    mem[0] = cfg;
    direct_en = dir;
    direct_addr = daddr[ADDR_W-1:0];
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(damp_out == 1'b0, "R11", "damp_out in reset", {31'b0, damp_out}, 32'd0);
    chk(mem_rd_en == 1'b0, "R11", "mem_rd_en in reset", {31'b0, mem_rd_en}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_manch_cycle();   // R2 wrap, R5 fast rate, R6
    start_tx(cfgw(0, 0, 0, 2), 0, 0);
    decode("R2", 0, 0, 5, 2, 0, 0);
    stop_tx();
  endtask

  task automatic test_psk_slow();      // R5 slow rate, R7
    start_tx(cfgw(0, 1, 1, 3), 0, 0);
    decode("R5", 1, 1, 4, 3, 0, 0);
    stop_tx();
  endtask

  task automatic test_direct();        // R4
    start_tx(cfgw(0, 0, 0, 3), 1, 5);
    decode("R4", 0, 0, 3, 3, 1, 5);
    stop_tx();
    direct_en = 1'b0;
  endtask

  task automatic test_cfg_block();     // R3
    start_tx(cfgw(0, 0, 1, 0), 0, 0);
    decode("R3", 1, 0, 3, 0, 0, 0);
    stop_tx();
  endtask

  task automatic test_restart();       // R10
    start_tx(cfgw(0, 0, 0, 1), 0, 0);
    decode("R2", 0, 0, 1, 1, 0, 0);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(damp_out == 1'b0, "R10", "damp_out after disable", {31'b0, damp_out}, 32'd0);
    chk(mem_rd_en == 1'b0, "R10", "mem_rd_en after disable", {31'b0, mem_rd_en}, 32'd0);
    repeat (10) @(negedge clk);
    enable = 1'b1;
    decode("R10", 0, 0, 2, 1, 0, 0);
    stop_tx();
  endtask

  task automatic test_defeat();        // R9
    int r0;
    bit seen = 1'b0;
    start_tx(cfgw(1, 0, 0, 2), 0, 0);
    r0 = rd_cnt;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (damp_out) seen = 1'b1;
    end
    chk(!seen, "R9", "damp_out silenced", {31'b0, seen}, 32'd0);
    chk(rd_cnt - r0 >= 4, "R9", "reads continue", rd_cnt - r0, 32'd4);
    stop_tx();
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++)
      mem[i] = {i[7:0], ~i[7:0], 8'h3C ^ i[7:0], 8'h96 ^ {i[3:0], i[3:0]}};
    test_reset();
    test_manch_cycle();
    test_psk_slow();
    test_direct();
    test_cfg_block();
    test_restart();
    test_defeat();
    chk(ord_viol == 0, "R8", "config read precedes each word read", ord_viol, 32'd0);
    chk(rd_cnt > 0, "R8", "reads observed", rd_cnt, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule